// File: doc/BRIEF.md
# Memory-Mapped Control-Register Bridge

This bridge sits on a memory-mapped host bus as a slave and forwards single-word transfers to a separate control-register bus. The register bus reaches 1024 registers, each 32 bits wide, through a 10-bit word address. The bridge claims one contiguous 4 KB window in host address space, set by a parameter. A host byte address inside that window selects a register through its bits [11:2].

A host master raises a request and holds its address, direction and data until the bridge pulses completion. A legal access starts exactly one register-bus cycle. The read or write strobe stays high until the register device acknowledges. The host transfer then completes in the following cycle and carries the captured read data with it. A misaligned or burst request is rejected at once with an error and touches nothing on the register side. A register device that never answers is cut off by a timeout, and the host sees an error.

Top module: `crb_bridge`

## Requirements
- R1: A request whose address lies outside the window [BASE_ADDR, BASE_ADDR+4096) is not claimed: no completion and no register strobe follow it.
- R2: The register address driven on `r_addr` is host address bits [11:2]; `r_wdata` carries the 32-bit host write data unchanged.
- R3: A legal write (`h_we`=1) raises `r_wr` in the cycle after the request is seen. `r_wr`, `r_addr` and `r_wdata` hold until `r_ack`. The strobe drops in the cycle after `r_ack`, and `h_done`=1 with `h_err`=0 appears in that same cycle.
- R4: A legal read (`h_we`=0) raises `r_rd` under the same timing as R3. `r_rdata` is captured in the cycle `r_ack` is high and is presented on `h_rdata` with `h_done`.
- R5: A request inside the window with host address bits [1:0] not equal to 0 completes in the next cycle with `h_done`=1 and `h_err`=1, and raises no register strobe.
- R6: A request with `h_burst`=1 completes as in R5 with `h_err`=1 and raises no register strobe.
- R7: If no acknowledge arrives within 64 strobe cycles, the strobe drops and `h_done`=1 with `h_err`=1 appear in the next cycle. An acknowledge in the 64th strobe cycle still completes without error.
- R8: During and after synchronous reset, `h_done`, `h_err`, `r_rd` and `r_wr` are 0.
- R9: `r_rd` and `r_wr` are never high together, and `h_done` is a single-cycle pulse.
- R10: An `r_ack` that arrives while no strobe is high has no effect: it produces no completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host request, held until `h_done` |
| h_we | input | 1 | 1 = write, 0 = read |
| h_burst | input | 1 | Host marks a burst attempt |
| h_addr | input | 32 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_done | output | 1 | One-cycle completion pulse |
| h_err | output | 1 | Error response, valid with `h_done` |
| h_rdata | output | 32 | Read data, valid with `h_done` on a good read |
| r_rd | output | 1 | Register-bus read strobe |
| r_wr | output | 1 | Register-bus write strobe |
| r_addr | output | 10 | Register word address |
| r_wdata | output | 32 | Register write data |
| r_rdata | input | 32 | Register read data |
| r_ack | input | 1 | Register device acknowledge |

## Verification
The assertions assume the host keeps `h_req` and its qualifiers steady from the request until it has seen `h_done`, and drops the request right after it. They also assume the register device raises `r_ack` for one cycle per strobe. The stimulus holds each transfer's inputs from one falling edge until completion is observed. A device model acknowledges after a programmed number of strobe cycles, or never. A separate stray acknowledge is injected only while the bridge is idle, which exercises the rule that such a pulse is ignored.

// File: rtl/crb_pkg.sv
package crb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIN  = 2'd2
    } crb_state_e;

    typedef struct packed {
        logic done;
        logic err;
    } crb_resp_t;

    function automatic logic word_aligned(input logic [1:0] lo);
        return lo == 2'b00;
    endfunction

endpackage

// File: rtl/crb_decode.sv
module crb_decode #(
    parameter int ADDR_W    = 32,
    parameter int REG_AW    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst,
    output logic              hit,
    output logic              reject,
    output logic [REG_AW-1:0] idx
);
    import crb_pkg::*;

    localparam int WIN_BITS = REG_AW + 2;

    always_comb begin
        hit    = addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS];
        reject = burst || !word_aligned(addr[1:0]);
        idx    = addr[WIN_BITS-1:2];
    end
endmodule

// File: rtl/crb_watch.sv
module crb_watch #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == LAST);
endmodule

// File: rtl/crb_bridge.sv
module crb_bridge #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int REG_AW    = 10,
    parameter int TIMEOUT   = 64,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_req,
    input  logic              h_we,
    input  logic              h_burst,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_done,
    output logic              h_err,
    output logic [DATA_W-1:0] h_rdata,
    output logic              r_rd,
    output logic              r_wr,
    output logic [REG_AW-1:0] r_addr,
    output logic [DATA_W-1:0] r_wdata,
    input  logic [DATA_W-1:0] r_rdata,
    input  logic              r_ack
);
    import crb_pkg::*;

    crb_state_e        st;
    crb_resp_t         resp;
    logic              hit, reject, expire;
    logic [REG_AW-1:0] idx;

    crb_decode #(
        .ADDR_W(ADDR_W), .REG_AW(REG_AW), .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr(h_addr), .burst(h_burst), .hit(hit), .reject(reject), .idx(idx)
    );

    crb_watch #(.TIMEOUT(TIMEOUT)) u_watch (
        .clk(clk), .rst(rst), .run(st == ST_WAIT), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            resp    <= '0;
            r_rd    <= 1'b0;
            r_wr    <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
            h_rdata <= '0;
        end else begin
            resp <= '0;
            unique case (st)
                ST_IDLE: begin
                    if (h_req && hit) begin
                        if (reject) begin
                            resp <= '{done: 1'b1, err: 1'b1};
                            st   <= ST_FIN;
                        end else begin
                            r_rd    <= !h_we;
                            r_wr    <= h_we;
                            r_addr  <= idx;
                            r_wdata <= h_wdata;
                            st      <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (r_ack) begin
                        if (r_rd) h_rdata <= r_rdata;
                        r_rd <= 1'b0;
                        r_wr <= 1'b0;
                        resp <= '{done: 1'b1, err: 1'b0};
                        st   <= ST_FIN;
                    end else if (expire) begin
                        r_rd <= 1'b0;
                        r_wr <= 1'b0;
                        resp <= '{done: 1'b1, err: 1'b1};
                        st   <= ST_FIN;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign h_done = resp.done;
    assign h_err  = resp.err;
endmodule

// File: rtl/crb_bridge_chk.sv
module crb_bridge_chk #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int REG_AW    = 10,
    parameter int TIMEOUT   = 64,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              h_req,
    input logic              h_burst,
    input logic [ADDR_W-1:0] h_addr,
    input logic              h_done,
    input logic              h_err,
    input logic              r_rd,
    input logic              r_wr,
    input logic              r_ack,
    input logic [REG_AW-1:0] r_addr,
    input logic [DATA_W-1:0] r_wdata
);
    localparam int WIN_BITS = REG_AW + 2;

    logic in_win, idle, strobe;
    int unsigned scnt;

    assign in_win = h_addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS];
    assign strobe = r_rd || r_wr;
    assign idle   = !strobe && !h_done;

    always_ff @(posedge clk) begin
        if (rst || !strobe) scnt <= 0;
        else                scnt <= scnt + 1;
    end

    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> !h_done && !h_err && !r_rd && !r_wr);

    p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        !(r_rd && r_wr));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        h_done |=> !h_done);

    p_strobe_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe && !r_ack && scnt != TIMEOUT - 1) |=>
            strobe && $stable(r_addr) && $stable(r_wdata) && $stable(r_wr));

    p_ack_finish_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe && r_ack) |=> !r_rd && !r_wr && h_done && !h_err);

    p_outside_r1: assert property (@(posedge clk) disable iff (rst)
        (h_req && !in_win && idle) |=> !h_done && !r_rd && !r_wr);

    p_misalign_r5: assert property (@(posedge clk) disable iff (rst)
        (h_req && in_win && idle && h_addr[1:0] != 2'b00) |=>
            h_done && h_err && !r_rd && !r_wr);

    p_burst_r6: assert property (@(posedge clk) disable iff (rst)
        (h_req && in_win && idle && h_burst) |=>
            h_done && h_err && !r_rd && !r_wr);

    p_timeout_r7: assert property (@(posedge clk) disable iff (rst)
        (strobe && !r_ack && scnt == TIMEOUT - 1) |=>
            h_done && h_err && !r_rd && !r_wr);

    p_stray_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (r_ack && !strobe && !h_req) |=> !h_done);
endmodule

bind crb_bridge crb_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW),
    .TIMEOUT(TIMEOUT), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .h_req(h_req), .h_burst(h_burst), .h_addr(h_addr),
    .h_done(h_done), .h_err(h_err), .r_rd(r_rd), .r_wr(r_wr), .r_ack(r_ack),
    .r_addr(r_addr), .r_wdata(r_wdata)
);

// File: tb/crb_bridge_bench.sv
module crb_bridge_bench;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam int TO = 64;
    localparam int NEVER = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_req = 1'b0, h_we = 1'b0, h_burst = 1'b0;
    logic [31:0] h_addr = '0, h_wdata = '0;
    logic        h_done, h_err, r_rd, r_wr;
    logic [31:0] h_rdata, r_wdata;
    logic [9:0]  r_addr;
    logic [31:0] r_rdata = '0;
    logic        r_ack = 1'b0;

    always #10 clk = ~clk;

    crb_bridge #(.BASE_ADDR(BASE), .TIMEOUT(TO)) u_crb_bridge (
        .clk(clk), .rst(rst), .h_req(h_req), .h_we(h_we), .h_burst(h_burst),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_done(h_done), .h_err(h_err),
        .h_rdata(h_rdata), .r_rd(r_rd), .r_wr(r_wr), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_ack(r_ack)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R8";
    int    lat = NEVER;
    int    dev_cnt = 0;
    bit    stray = 1'b0;
    logic [31:0] mem [1024];

    task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    // behavioural reference of the host-visible and register-visible outputs
    int          m_phase = 0;
    int          m_cnt = 0;
    bit          m_read = 0;
    logic        e_done = 0, e_err = 0, e_rd = 0, e_wr = 0;
    logic [9:0]  e_addr = '0;
    logic [31:0] e_wdata = '0, e_rdata = '0;

    function automatic bit in_window(input logic [31:0] a);
        return a >= BASE && a < BASE + 32'd4096;
    endfunction

    always @(posedge clk) begin
        if (r_ack && r_wr) mem[r_addr] = r_wdata;
        if (rst) begin
            m_phase = 0; e_done = 0; e_err = 0; e_rd = 0; e_wr = 0;
        end else begin
            e_done = 0; e_err = 0;
            if (m_phase == 0) begin
                if (h_req && in_window(h_addr)) begin
                    if (h_addr[1:0] != 2'b00 || h_burst) begin
                        e_done = 1; e_err = 1; m_read = 0; m_phase = 2;
                    end else begin
                        e_rd = !h_we; e_wr = h_we; m_read = !h_we;
                        e_addr = h_addr[11:2]; e_wdata = h_wdata;
                        m_cnt = 0; m_phase = 1;
                    end
                end
            end else if (m_phase == 1) begin
                m_cnt++;
                if (r_ack) begin
                    if (e_rd) e_rdata = r_rdata;
                    e_rd = 0; e_wr = 0; e_done = 1; m_phase = 2;
                end else if (m_cnt == TO) begin
                    e_rd = 0; e_wr = 0; e_done = 1; e_err = 1; m_read = 0; m_phase = 2;
                end
            end else begin
                m_phase = 0;
            end
        end
    end

    // per-cycle comparison and register-device model
    always @(negedge clk) begin
        if (!rst) begin
            chk(h_done === e_done, {tag, " done"}, 32'(h_done), 32'(e_done));
            chk(h_err  === e_err,  {tag, " err"},  32'(h_err),  32'(e_err));
            chk(r_rd   === e_rd,   {tag, " r_rd"}, 32'(r_rd),   32'(e_rd));
            chk(r_wr   === e_wr,   {tag, " r_wr"}, 32'(r_wr),   32'(e_wr));
            chk(!(r_rd && r_wr), "R9 both strobes", {r_rd, r_wr}, 32'd0);
            if (e_rd || e_wr) chk(r_addr === e_addr, "R2 r_addr", 32'(r_addr), 32'(e_addr));
            if (e_wr) chk(r_wdata === e_wdata, "R2 r_wdata", r_wdata, e_wdata);
            if (e_done && !e_err && m_read) chk(h_rdata === e_rdata, "R4 h_rdata", h_rdata, e_rdata);
        end
        if (r_rd || r_wr) begin
            dev_cnt++;
            r_ack = (dev_cnt == lat);
        end else begin
            dev_cnt = 0;
            r_ack = stray;
        end
        r_rdata = mem[r_addr];
    end

    task automatic xfer(input string t, input logic [31:0] a, input bit we, input logic [31:0] d,
                        input bit burst, input int latency, input bit exp_err,
                        input bit chk_data, input logic [31:0] exp_data);
        bit got = 0;
        logic e = 0;
        logic [31:0] rd = '0;
        int n = 0;
        tag = t;
        lat = latency;
        @(negedge clk); #1;
        h_req = 1; h_addr = a; h_we = we; h_wdata = d; h_burst = burst;
        while (!got && n < 200) begin
            @(negedge clk); #2;
            if (h_done) begin got = 1; e = h_err; rd = h_rdata; end
            n++;
        end
        h_req = 0; h_burst = 0;
        chk(got, {t, " completion seen"}, 32'(got), 32'd1);
        chk(e == exp_err, {t, " error response"}, 32'(e), 32'(exp_err));
        if (chk_data) chk(rd === exp_data, {t, " read data"}, rd, exp_data);
    endtask

    task automatic no_claim(input string t, input logic [31:0] a);
        bit seen = 0;
        tag = t;
        lat = 1;
        @(negedge clk); #1;
        h_req = 1; h_addr = a; h_we = 1; h_wdata = 32'hDEAD_BEEF; h_burst = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #2;
            if (h_done || r_rd || r_wr) seen = 1;
        end
        h_req = 0;
        chk(!seen, {t, " unclaimed address"}, 32'(seen), 32'd0);
    endtask

    initial begin
        #(20 * 50000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h0101_0101) ^ 32'hA5A5_0000;
        repeat (3) @(negedge clk);
        // R8: outputs quiet under reset
        chk(!h_done && !h_err && !r_rd && !r_wr, "R8 reset outputs",
            {h_done, h_err, r_rd, r_wr}, 32'd0);
        #1 rst = 0;
        @(negedge clk);
        chk(!h_done && !h_err && !r_rd && !r_wr, "R8 after reset",
            {h_done, h_err, r_rd, r_wr}, 32'd0);

        // R3 writes, R2 address mapping at both ends of the window
        xfer("R3 write reg5", BASE + 32'h14, 1, 32'h1234_5678, 0, 1, 0, 0, '0);
        xfer("R3 write reg1023", BASE + 32'hFFC, 1, 32'hCAFE_F00D, 0, 3, 0, 0, '0);
        xfer("R2 write reg0", BASE, 1, 32'h0000_0001, 0, 2, 0, 0, '0);
        // R4 reads back what was written
        xfer("R4 read reg5", BASE + 32'h14, 0, '0, 0, 2, 0, 1, 32'h1234_5678);
        xfer("R4 read reg1023", BASE + 32'hFFC, 0, '0, 0, 1, 0, 1, 32'hCAFE_F00D);
        xfer("R2 read reg0", BASE, 0, '0, 0, 5, 0, 1, 32'h0000_0001);
        xfer("R4 read reg700", BASE + 32'(700 * 4), 0, '0, 0, 4, 0, 1,
             (32'd700 * 32'h0101_0101) ^ 32'hA5A5_0000);
        // R5 misaligned, R6 burst
        xfer("R5 misaligned write", BASE + 32'h12, 1, 32'h5555_5555, 0, 1, 1, 0, '0);
        xfer("R5 misaligned read", BASE + 32'h21, 0, '0, 0, 1, 1, 0, '0);
        xfer("R6 burst read", BASE + 32'h40, 0, '0, 1, 1, 1, 0, '0);
        xfer("R6 burst write", BASE + 32'h44, 1, 32'h7777_7777, 1, 1, 1, 0, '0);
        xfer("R5 reg4 untouched", BASE + 32'h10, 0, '0, 0, 1, 0, 1,
             (32'd4 * 32'h0101_0101) ^ 32'hA5A5_0000);
        xfer("R6 reg17 untouched", BASE + 32'h44, 0, '0, 0, 1, 0, 1,
             (32'd17 * 32'h0101_0101) ^ 32'hA5A5_0000);
        // R1 outside window
        no_claim("R1 above window", BASE + 32'h1000);
        no_claim("R1 below window", BASE - 32'h4);
        // R7 timeout, and acknowledge on the last allowed cycle
        xfer("R7 no ack", BASE + 32'h80, 1, 32'h0BAD_0BAD, 0, NEVER, 1, 0, '0);
        xfer("R7 ack at cycle 64", BASE + 32'h84, 1, 32'h600D_600D, 0, 64, 0, 0, '0);
        xfer("R7 readback", BASE + 32'h84, 0, '0, 0, 1, 0, 1, 32'h600D_600D);
        xfer("R7 timed-out write dropped", BASE + 32'h80, 0, '0, 0, 1, 0, 1,
             (32'd32 * 32'h0101_0101) ^ 32'hA5A5_0000);
        // R10 stray acknowledge while idle
        tag = "R10";
        @(negedge clk); #1 stray = 1;
        repeat (4) @(negedge clk);
        #2 chk(!h_done, "R10 stray ack completion", 32'(h_done), 32'd0);
        #1 stray = 0;
        xfer("R10 normal after stray", BASE + 32'h8, 0, '0, 0, 2, 0, 1,
             (32'd2 * 32'h0101_0101) ^ 32'hA5A5_0000);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule